// File: doc/BRIEF.md
# Self-Programming Command Arming Register

This block is an 8-bit control and status register that lets a small processor core run flash self-programming and special memory reads. Software writes one command bit together with the enable bit. That write arms the command for a short window of clock cycles. If a store-program instruction strobe arrives inside the window, an armed page erase or page write is sent to the flash controller. If a load-program instruction strobe arrives inside the window, an armed signature or fuse/lock read redirects that load away from program memory.

The window length depends on the command: page operations get more cycles than reads. The register clears the command bit and the enable bit by itself when the window runs out, when a read has been served, or when the flash controller reports that an erase or write has finished. While an erase or write is in progress, the processor is held halted. A separate strobe bit discards the temporary page buffer while the buffer is being filled.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: After reset, `reg_rd_data` is 0x00, `cpu_halt`, `flash_start` and `buf_clear` are low, and `load_src` is 0 (program memory).
- R2: Bits 7, 6 and 4 of `reg_rd_data` always read zero, even after a write that sets them.
- R3: The command bits are bit 1 = erase, bit 2 = write, bit 3 = fuse/lock read and bit 5 = signature read. A write with bit 0 (enable) set and at least one command bit set arms the command on the next clock edge. Once armed, the register reads back that bit and bit 0. A write with bit 0 clear arms nothing.
- R4: When several command bits are written at once, only one is armed. The priority order is erase, then write, then fuse/lock read, then signature read.
- R5: A `store_strobe` sampled on any of the WR_WIN (4) clock edges after an erase or write is armed starts the operation. On the next edge, `flash_start` pulses for one cycle, `cpu_halt` rises, `flash_op` shows the operation (0 = erase, 1 = write), and `flash_page` shows the `ptr_page` value captured at the accept edge. That value is held until the operation ends.
- R6: `cpu_halt` stays high until `flash_done` is sampled. On that edge, `cpu_halt` falls and the register clears to 0x00.
- R7: A window that sees no matching strobe clears the register on its last edge (edge 4 for page commands, edge 3 for reads). A strobe after that point has no effect.
- R8: A `load_strobe` inside the window of an armed read drives `load_src` in the same cycle. A signature read gives 1. A fuse/lock read gives 2 (fuse) when `ptr_lsb` = 0 and 3 (lock) when `ptr_lsb` = 1. The register clears on that edge. In every other case `load_src` is 0.
- R9: A `store_strobe` while a read is armed does nothing: there is no start, and the read stays armed. A `load_strobe` while a page command is armed leaves `load_src` at 0 and the command armed.
- R10: Register writes while a command is armed, or while an erase or write is in progress, leave the register unchanged.
- R11: A write with bit 4 set while `buf_fill_active` is high pulses `buf_clear` for one cycle, starting on the next edge. Without `buf_fill_active`, the same write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read value |
| store_strobe | input | 1 | Store-program instruction executing |
| load_strobe | input | 1 | Load-program instruction executing |
| ptr_page | input | ADDR_W-PAGE_LSB | Page part of the address pointer |
| ptr_lsb | input | 1 | Bit 0 of the address pointer |
| buf_fill_active | input | 1 | Temporary page buffer is being filled |
| buf_clear | output | 1 | Discard temporary page buffer (pulse) |
| load_src | output | 2 | Load source: 0 program, 1 signature, 2 fuse, 3 lock |
| flash_start | output | 1 | Start pulse to flash controller |
| flash_op | output | 1 | Operation: 0 erase, 1 write |
| flash_page | output | ADDR_W-PAGE_LSB | Page address for the operation |
| flash_done | input | 1 | Flash operation finished |
| cpu_halt | output | 1 | Hold the processor |

## Verification
Each result arrives at a different point after its stimulus:
- `load_src` is combinational, so the bench samples it 1 ns after driving the load strobe, before the edge.
- The register image, `flash_start`, `cpu_halt` and `buf_clear` are registered once, so they are sampled at the falling edge after the accepting rising edge.

The bench drives every input on a falling edge. As a result, a strobe driven k falling edges after a write is sampled on rising edge k of the window. This lets the bench place strobes exactly on the last valid edge and on the first edge after it. A read strobe on edge 3 versus edge 4, and a page strobe on edge 4 versus edge 5, pin down both window limits.

// File: rtl/spm_cmd_pkg.sv
package spm_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_ERASE = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_FUSE  = 3'd3,
    CMD_SIG   = 3'd4
  } spm_cmd_e;

  localparam int BIT_EN     = 0;
  localparam int BIT_ERASE  = 1;
  localparam int BIT_WRITE  = 2;
  localparam int BIT_FUSE   = 3;
  localparam int BIT_CLRBUF = 4;
  localparam int BIT_SIG    = 5;

  localparam logic [1:0] SRC_PROG = 2'd0;
  localparam logic [1:0] SRC_SIG  = 2'd1;
  localparam logic [1:0] SRC_FUSE = 2'd2;
  localparam logic [1:0] SRC_LOCK = 2'd3;

  // Highest-priority command in a write, or none if enable is clear
  function automatic spm_cmd_e pick_cmd(input logic [5:0] d);
    if (!d[BIT_EN])          return CMD_NONE;
    else if (d[BIT_ERASE])   return CMD_ERASE;
    else if (d[BIT_WRITE])   return CMD_WRITE;
    else if (d[BIT_FUSE])    return CMD_FUSE;
    else if (d[BIT_SIG])     return CMD_SIG;
    else                     return CMD_NONE;
  endfunction

  function automatic logic is_page_op(input spm_cmd_e c);
    return (c == CMD_ERASE) || (c == CMD_WRITE);
  endfunction

  function automatic logic is_read_op(input spm_cmd_e c);
    return (c == CMD_FUSE) || (c == CMD_SIG);
  endfunction

  // Register image for an armed or running command
  function automatic logic [7:0] cmd_image(input spm_cmd_e c);
    logic [7:0] img;
    img = 8'h00;
    case (c)
      CMD_ERASE: img[BIT_ERASE] = 1'b1;
      CMD_WRITE: img[BIT_WRITE] = 1'b1;
      CMD_FUSE:  img[BIT_FUSE]  = 1'b1;
      CMD_SIG:   img[BIT_SIG]   = 1'b1;
      default:   img = 8'h00;
    endcase
    img[BIT_EN] = (c != CMD_NONE);
    return img;
  endfunction

  function automatic logic [1:0] read_src(input spm_cmd_e c, input logic lsb);
    if (c == CMD_SIG)       return SRC_SIG;
    else if (c == CMD_FUSE) return lsb ? SRC_LOCK : SRC_FUSE;
    else                    return SRC_PROG;
  endfunction

endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
  import spm_cmd_pkg::*;
(
  input  logic       wr_en,
  input  logic [5:0] wr_bits,
  input  spm_cmd_e   cur_cmd,
  input  logic       fill_active,
  output logic       arm_evt,
  output spm_cmd_e   arm_cmd,
  output logic       clr_buf_req
);

  spm_cmd_e req_cmd;

  always_comb begin
    req_cmd     = wr_en ? pick_cmd(wr_bits) : CMD_NONE;
    // Arming only from the idle state; armed or busy ignores writes
    arm_evt     = (cur_cmd == CMD_NONE) && (req_cmd != CMD_NONE);
    arm_cmd     = req_cmd;
    clr_buf_req = wr_en && wr_bits[BIT_CLRBUF] && fill_active;
  end

endmodule

// File: rtl/spm_window.sv
module spm_window #(
  parameter int RD_WIN = 3,
  parameter int WR_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic arm_page,
  input  logic hit,
  output logic expire
);

  localparam int MAX_WIN = (RD_WIN > WR_WIN) ? RD_WIN : WR_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_len;

  assign load_len = arm_page ? CNT_W'(WR_WIN) : CNT_W'(RD_WIN);
  assign expire   = (cnt_q == CNT_W'(1)) && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                            cnt_q <= '0;
    else if (arm)                          cnt_q <= load_len;
    else if (hit || cnt_q == CNT_W'(1))    cnt_q <= '0;
    else if (cnt_q != '0)                  cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/spm_dispatch.sv
module spm_dispatch
  import spm_cmd_pkg::*;
#(
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  spm_cmd_e          start_cmd,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              done_in,
  input  logic              clr_buf_req,
  output logic              busy,
  output logic              done_evt,
  output logic              start_pulse,
  output logic              op_write,
  output logic [PAGE_W-1:0] page_q,
  output logic              clr_buf_pulse
);

  assign done_evt = busy && done_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      start_pulse   <= 1'b0;
      op_write      <= 1'b0;
      page_q        <= '0;
      clr_buf_pulse <= 1'b0;
    end else begin
      start_pulse   <= start_hit;
      clr_buf_pulse <= clr_buf_req;
      if (start_hit) begin
        busy     <= 1'b1;
        op_write <= (start_cmd == CMD_WRITE);
        page_q   <= page_in;
      end else if (done_evt) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
  import spm_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 7,
  parameter int RD_WIN   = 3,
  parameter int WR_WIN   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [7:0]                 reg_wr_data,
  output logic [7:0]                 reg_rd_data,
  input  logic                       store_strobe,
  input  logic                       load_strobe,
  input  logic [ADDR_W-PAGE_LSB-1:0] ptr_page,
  input  logic                       ptr_lsb,
  input  logic                       buf_fill_active,
  output logic                       buf_clear,
  output logic [1:0]                 load_src,
  output logic                       flash_start,
  output logic                       flash_op,
  output logic [ADDR_W-PAGE_LSB-1:0] flash_page,
  input  logic                       flash_done,
  output logic                       cpu_halt
);

  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  spm_cmd_e cmd_q;
  spm_cmd_e arm_cmd;
  logic     arm_evt;
  logic     clr_buf_req;
  logic     busy;
  logic     armed;
  logic     store_hit;
  logic     load_hit;
  logic     expire_evt;
  logic     done_evt;

  spm_cmd_decode u_decode (
    .wr_en       (reg_wr_en),
    .wr_bits     (reg_wr_data[5:0]),
    .cur_cmd     (cmd_q),
    .fill_active (buf_fill_active),
    .arm_evt     (arm_evt),
    .arm_cmd     (arm_cmd),
    .clr_buf_req (clr_buf_req)
  );

  assign armed     = (cmd_q != CMD_NONE) && !busy;
  assign store_hit = armed && store_strobe && is_page_op(cmd_q);
  assign load_hit  = armed && load_strobe && is_read_op(cmd_q);

  spm_window #(.RD_WIN(RD_WIN), .WR_WIN(WR_WIN)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm_evt),
    .arm_page (is_page_op(arm_cmd)),
    .hit      (store_hit || load_hit),
    .expire   (expire_evt)
  );

  spm_dispatch #(.PAGE_W(PAGE_W)) u_dispatch (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_hit     (store_hit),
    .start_cmd     (cmd_q),
    .page_in       (ptr_page),
    .done_in       (flash_done),
    .clr_buf_req   (clr_buf_req),
    .busy          (busy),
    .done_evt      (done_evt),
    .start_pulse   (flash_start),
    .op_write      (flash_op),
    .page_q        (flash_page),
    .clr_buf_pulse (buf_clear)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                              cmd_q <= CMD_NONE;
    else if (arm_evt)                        cmd_q <= arm_cmd;
    else if (load_hit || expire_evt || done_evt) cmd_q <= CMD_NONE;
  end

  assign reg_rd_data = cmd_image(cmd_q);
  assign load_src    = load_hit ? read_src(cmd_q, ptr_lsb) : SRC_PROG;
  assign cpu_halt    = busy;

endmodule

// File: rtl/spm_cmd_ctrl_chk.sv
module spm_cmd_ctrl_chk #(
  parameter int RD_WIN = 3,
  parameter int WR_WIN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_data,
  input logic [7:0] reg_rd_data,
  input logic       flash_start,
  input logic       flash_done,
  input logic       cpu_halt,
  input logic       armed,
  input logic       arm_evt,
  input logic       store_hit,
  input logic       load_hit,
  input logic       expire_evt
);

  localparam int MAX_WIN = (RD_WIN > WR_WIN) ? RD_WIN : WR_WIN;

  logic [7:0] win_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                win_age <= '0;
    else if (arm_evt)          win_age <= 8'd1;
    else if (armed && win_age != 8'hFF) win_age <= win_age + 8'd1;
    else if (!armed)           win_age <= '0;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[7:6] == 2'b00 && reg_rd_data[4] == 1'b0); // R2

  AST_RSVD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_wr_data[7:6] != 2'b00 |=> reg_rd_data[7:6] == 2'b00); // R2

  AST_SINGLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_rd_data[5:1]) <= 1); // R4

  AST_START_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    store_hit |=> flash_start && cpu_halt); // R5

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt && !flash_done |=> cpu_halt); // R6

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt && flash_done |=> reg_rd_data == 8'h00 && !cpu_halt); // R6

  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> int'(win_age) <= MAX_WIN); // R7

  AST_EXPIRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> reg_rd_data == 8'h00); // R7

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> reg_rd_data == 8'h00); // R8

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt && !flash_done |=> $stable(reg_rd_data)); // R10

endmodule

bind spm_cmd_ctrl spm_cmd_ctrl_chk #(.RD_WIN(RD_WIN), .WR_WIN(WR_WIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .flash_start (flash_start),
  .flash_done  (flash_done),
  .cpu_halt    (cpu_halt),
  .armed       (armed),
  .arm_evt     (arm_evt),
  .store_hit   (store_hit),
  .load_hit    (load_hit),
  .expire_evt  (expire_evt)
);

// File: tb/tb_spm_cmd_ctrl.sv
module tb_spm_cmd_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data;
  logic       store_strobe;
  logic       load_strobe;
  logic [8:0] ptr_page;
  logic       ptr_lsb;
  logic       buf_fill_active;
  logic       buf_clear;
  logic [1:0] load_src;
  logic       flash_start;
  logic       flash_op;
  logic [8:0] flash_page;
  logic       flash_done;
  logic       cpu_halt;

  int n_chk = 0;
  int n_err = 0;

  spm_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .store_strobe(store_strobe), .load_strobe(load_strobe),
    .ptr_page(ptr_page), .ptr_lsb(ptr_lsb), .buf_fill_active(buf_fill_active),
    .buf_clear(buf_clear), .load_src(load_src), .flash_start(flash_start),
    .flash_op(flash_op), .flash_page(flash_page), .flash_done(flash_done),
    .cpu_halt(cpu_halt)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Write lands on the next rising edge; returns at the falling edge after it
  task automatic reg_write(input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = 8'h00;
  endtask

  task automatic pulse_store();
    store_strobe = 1'b1;
    @(negedge clk);
    store_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd", reg_rd_data, 8'h00);
    chk("R1 halt", cpu_halt, 0);
    chk("R1 start", flash_start, 0);
    chk("R1 bufclr", buf_clear, 0);
    chk("R1 src", load_src, 0);
  endtask

  task automatic t_arm_priority();
    reg_write(8'hFF);
    chk("R4 R2 all bits -> erase", reg_rd_data, 8'h03);
    idle(4);
    reg_write(8'h2D);
    chk("R4 write over fuse/sig", reg_rd_data, 8'h05);
    idle(4);
    reg_write(8'h29);
    chk("R4 fuse over sig", reg_rd_data, 8'h09);
    idle(3);
    reg_write(8'h21);
    chk("R3 sig armed", reg_rd_data, 8'h21);
    idle(3);
    reg_write(8'h04);
    chk("R3 no enable", reg_rd_data, 8'h00);
    reg_write(8'h01);
    chk("R3 enable only", reg_rd_data, 8'h00);
  endtask

  task automatic t_page_op(input logic [7:0] wr, input int k, input int op);
    ptr_page = 9'h157;
    reg_write(wr);
    idle(k - 1);
    pulse_store();
    chk("R5 start", flash_start, 1);
    chk("R5 halt", cpu_halt, 1);
    chk("R5 op", flash_op, op);
    chk("R5 page", flash_page, 9'h157);
    ptr_page = 9'h0AA;
    @(negedge clk);
    chk("R5 start one cycle", flash_start, 0);
    chk("R5 page held", flash_page, 9'h157);
    reg_write(8'h21);
    chk("R10 write while busy", reg_rd_data, int'(wr & 8'h07));
    idle(3);
    chk("R6 halt held", cpu_halt, 1);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
    chk("R6 halt released", cpu_halt, 0);
    chk("R6 cleared", reg_rd_data, 8'h00);
  endtask

  task automatic t_page_expire();
    reg_write(8'h03);
    idle(2);
    chk("R7 still armed edge3", reg_rd_data, 8'h03);
    idle(2);
    chk("R7 cleared after 4", reg_rd_data, 8'h00);
    pulse_store();
    chk("R7 late store no start", flash_start, 0);
    chk("R7 late store no halt", cpu_halt, 0);
  endtask

  task automatic t_read(input logic [7:0] wr, input logic lsb, input int k, input int exp_src);
    ptr_lsb = lsb;
    reg_write(wr);
    idle(k - 1);
    load_strobe = 1'b1;
    #1;
    chk("R8 load_src", load_src, exp_src);
    @(negedge clk);
    load_strobe = 1'b0;
    chk("R8 R7 clear after read", reg_rd_data, 8'h00);
    idle(2);
  endtask

  task automatic t_cross();
    reg_write(8'h21);
    pulse_store();
    chk("R9 store on read: no start", flash_start, 0);
    chk("R9 read stays armed", reg_rd_data, 8'h21);
    load_strobe = 1'b1;
    #1;
    chk("R9 read still served", load_src, 1);
    @(negedge clk);
    load_strobe = 1'b0;
    idle(2);
    reg_write(8'h03);
    load_strobe = 1'b1;
    #1;
    chk("R9 load on erase: program", load_src, 0);
    @(negedge clk);
    load_strobe = 1'b0;
    chk("R9 erase stays armed", reg_rd_data, 8'h03);
    reg_write(8'h05);
    chk("R10 write while armed", reg_rd_data, 8'h03);
    reg_write(8'h02);
    chk("R10 no-enable write while armed", reg_rd_data, 8'h03);
    idle(3);
    chk("R7 erase expired", reg_rd_data, 8'h00);
  endtask

  task automatic t_bufclr();
    buf_fill_active = 1'b1;
    reg_write(8'h10);
    chk("R11 clear pulse", buf_clear, 1);
    chk("R2 bit4 reads zero", reg_rd_data, 8'h00);
    @(negedge clk);
    chk("R11 pulse one cycle", buf_clear, 0);
    buf_fill_active = 1'b0;
    reg_write(8'h10);
    chk("R11 no fill no pulse", buf_clear, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    store_strobe = 1'b0; load_strobe = 1'b0; ptr_page = 9'h000; ptr_lsb = 1'b0;
    buf_fill_active = 1'b0; flash_done = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm_priority();
    t_page_op(8'h03, 4, 0);
    t_page_op(8'h05, 1, 1);
    t_page_expire();
    t_read(8'h21, 1'b0, 3, 1);
    t_read(8'h09, 1'b1, 1, 3);
    t_read(8'h09, 1'b0, 2, 2);
    reg_write(8'h21);
    idle(3);
    load_strobe = 1'b1;
    #1;
    chk("R7 R8 late read gives program", load_src, 0);
    @(negedge clk);
    load_strobe = 1'b0;
    t_cross();
    t_bufclr();
    summary();
    $finish;
  end

endmodule